// File: doc/BRIEF.md
# Single-Table Microcoded Control Sequencer

This block is the control unit of a small processor in which one lookup table drives the whole machine. The table address is formed by joining the instruction opcode, the four condition-code flags and the current state number. Each table entry holds a control word and the number of the state that follows. A state register loads that next-state number on every rising clock edge. There is no micro-program counter, no incrementer and no branch logic: every sequencing decision, including flag-dependent ones, is written into the table.

The control word is built from 8-bit slices. Each slice is its own table on the shared address, so a wider word only needs more slices. The table holds a short demonstration microprogram: an instruction fetch state, a no-operation, a register move, a halt, and a branch-if-zero that takes a different path depending on the Z flag. The control word is a Mealy output of opcode, flags and state, so it follows the inputs within the same cycle.

Top module: `ucs_sequencer`

## Requirements
- R1: Reset is synchronous and active high. A rising edge with `rst` high loads state 0, the fetch state.
- R2: With `rst` low, every rising edge loads the next-state field of the entry addressed by the current {opcode, flags, state}.
- R3: `ctl` and the next state are a pure combinational function of `opcode`, `flags` and `state`. A change of `opcode` or `flags` within a cycle shows on `ctl` without a clock edge.
- R4: The 19-bit table address is {opcode[9:0], flags[3:0], state[4:0]}. The flag bits are C = bit 0, V = bit 1, Z = bit 2 and N = bit 3.
- R5: Any address not listed in the microprogram yields `ctl` = 0 and next state 0.
- R6: The control word is N_SLICES slices of 8 bits each (16 bits by default). Slice k drives `ctl[8k+7:8k]`.
- R7: In state 0, each demo opcode (NOP 0x0A0, MOV 0x040, BEQ 0x0C0, HALT 0x000) gives `ctl` = 0x000F and next state 1, for any flags.
- R8: BEQ in state 1 gives `ctl` 0x0040 and next state 2 when Z = 1. When Z = 0 it gives `ctl` 0x0008 and next state 0. In state 2 it gives 0x1000 and next state 0.
- R9: MOV steps through state 1 (0x0103), state 2 (0x0220) and state 3 (0x0830), then returns to state 0.
- R10: HALT in state 1 gives `ctl` 0x0080 and next state 1, so the machine stays there until reset or a new opcode.
- R11: NOP in state 1 gives `ctl` 0x0400 and next state 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state advances on the rising edge |
| rst | input | 1 | Synchronous active-high reset to state 0 |
| opcode | input | 10 | Current instruction opcode |
| flags | input | 4 | Condition codes {N, Z, V, C} |
| ctl | output | 16 | Control word for the current state and inputs |
| state | output | 5 | Current state number |

## Verification
The assertions assume that `opcode` and `flags` are settled before each rising edge, because the next state is sampled straight from them. They also assume that the flags carry no unknown bits, so the branch entry resolves to one path. The stimulus changes inputs only on the falling edge, from a bounded mix of demo opcodes, one unlisted opcode and random flag values. This keeps every sampled address defined and exercises both listed and unlisted table entries.

// File: rtl/ucs_pkg.sv
package ucs_pkg;
  parameter int OP_W     = 10;
  parameter int FLAG_W   = 4;
  parameter int ST_W     = 5;
  parameter int SLICE_W  = 8;
  parameter int N_SLICES = 2;

  localparam int ADDR_W = OP_W + FLAG_W + ST_W;
  localparam int CTL_W  = SLICE_W * N_SLICES;

  localparam int FLG_C = 0;
  localparam int FLG_V = 1;
  localparam int FLG_Z = 2;
  localparam int FLG_N = 3;

  localparam logic [OP_W-1:0] OP_HALT = 10'h000;
  localparam logic [OP_W-1:0] OP_MOV  = 10'h040;
  localparam logic [OP_W-1:0] OP_NOP  = 10'h0A0;
  localparam logic [OP_W-1:0] OP_BEQ  = 10'h0C0;

  localparam logic [ST_W-1:0] S_FETCH = 5'd0;
  localparam logic [ST_W-1:0] S_ONE   = 5'd1;
  localparam logic [ST_W-1:0] S_TWO   = 5'd2;
  localparam logic [ST_W-1:0] S_THREE = 5'd3;

  // control word bit meanings for the demo microprogram
  localparam logic [CTL_W-1:0] C_ADDR_FROM_PC = 16'h0001;
  localparam logic [CTL_W-1:0] C_MEM_READ     = 16'h0002;
  localparam logic [CTL_W-1:0] C_IR_LOAD      = 16'h0004;
  localparam logic [CTL_W-1:0] C_PC_STEP      = 16'h0008;
  localparam logic [CTL_W-1:0] C_ALU_PASS     = 16'h0010;
  localparam logic [CTL_W-1:0] C_REG_WRITE    = 16'h0020;
  localparam logic [CTL_W-1:0] C_PC_ADD_OFS   = 16'h0040;
  localparam logic [CTL_W-1:0] C_STOPPED      = 16'h0080;
  localparam logic [CTL_W-1:0] C_SRC_DRIVE    = 16'h0100;
  localparam logic [CTL_W-1:0] C_DST_LATCH    = 16'h0200;
  localparam logic [CTL_W-1:0] C_IDLE_MARK    = 16'h0400;
  localparam logic [CTL_W-1:0] C_FLAG_UPDATE  = 16'h0800;
  localparam logic [CTL_W-1:0] C_BR_DONE      = 16'h1000;

  localparam logic [CTL_W-1:0] C_FETCH =
    C_ADDR_FROM_PC | C_MEM_READ | C_IR_LOAD | C_PC_STEP;

  typedef struct packed {
    logic [CTL_W-1:0] ctl;
    logic [ST_W-1:0]  nxt;
  } uentry_t;

  function automatic logic [ADDR_W-1:0] pack_addr(
      input logic [OP_W-1:0] op, input logic [FLAG_W-1:0] fl,
      input logic [ST_W-1:0] st);
    return {op, fl, st};
  endfunction

  // Sparse microprogram: unlisted addresses return all zero.
  function automatic uentry_t ucode_lookup(input logic [ADDR_W-1:0] a);
    uentry_t e;
    e.ctl = '0;
    e.nxt = '0;
    casez (a)
      {OP_NOP,  4'b????, S_FETCH}: begin e.ctl = C_FETCH; e.nxt = S_ONE; end
      {OP_MOV,  4'b????, S_FETCH}: begin e.ctl = C_FETCH; e.nxt = S_ONE; end
      {OP_BEQ,  4'b????, S_FETCH}: begin e.ctl = C_FETCH; e.nxt = S_ONE; end
      {OP_HALT, 4'b????, S_FETCH}: begin e.ctl = C_FETCH; e.nxt = S_ONE; end
      {OP_NOP,  4'b????, S_ONE}:   begin e.ctl = C_IDLE_MARK; e.nxt = S_FETCH; end
      {OP_HALT, 4'b????, S_ONE}:   begin e.ctl = C_STOPPED; e.nxt = S_ONE; end
      {OP_MOV,  4'b????, S_ONE}: begin
        e.ctl = C_SRC_DRIVE | C_ADDR_FROM_PC | C_MEM_READ; e.nxt = S_TWO;
      end
      {OP_MOV,  4'b????, S_TWO}: begin
        e.ctl = C_DST_LATCH | C_REG_WRITE; e.nxt = S_THREE;
      end
      {OP_MOV,  4'b????, S_THREE}: begin
        e.ctl = C_FLAG_UPDATE | C_REG_WRITE | C_ALU_PASS; e.nxt = S_FETCH;
      end
      {OP_BEQ,  4'b?1??, S_ONE}: begin e.ctl = C_PC_ADD_OFS; e.nxt = S_TWO; end
      {OP_BEQ,  4'b?0??, S_ONE}: begin e.ctl = C_PC_STEP; e.nxt = S_FETCH; end
      {OP_BEQ,  4'b????, S_TWO}: begin e.ctl = C_BR_DONE; e.nxt = S_FETCH; end
      default: begin e.ctl = '0; e.nxt = '0; end
    endcase
    return e;
  endfunction
endpackage

// File: rtl/ucs_ctl_slice.sv
module ucs_ctl_slice
  import ucs_pkg::*;
#(
  parameter int SLICE_IDX = 0
) (
  input  logic [ADDR_W-1:0]  addr,
  output logic [SLICE_W-1:0] data
);
  localparam int LSB = SLICE_IDX * SLICE_W;

  uentry_t ent;
  always_comb begin
    ent  = ucode_lookup(addr);
    data = ent.ctl[LSB +: SLICE_W];
  end
endmodule

// File: rtl/ucs_next_table.sv
module ucs_next_table
  import ucs_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output logic [ST_W-1:0]   nxt
);
  uentry_t ent;
  always_comb begin
    ent = ucode_lookup(addr);
    nxt = ent.nxt;
  end
endmodule

// File: rtl/ucs_state_reg.sv
module ucs_state_reg
  import ucs_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [ST_W-1:0] d,
  output logic [ST_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= S_FETCH;
    else     q <= d;
  end
endmodule

// File: rtl/ucs_sequencer.sv
module ucs_sequencer
  import ucs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [OP_W-1:0]   opcode,
  input  logic [FLAG_W-1:0] flags,
  output logic [CTL_W-1:0]  ctl,
  output logic [ST_W-1:0]   state
);
  logic [ADDR_W-1:0] table_addr;
  logic [ST_W-1:0]   next_state;
  logic [ST_W-1:0]   cur_state;

  assign table_addr = pack_addr(opcode, flags, cur_state);

  for (genvar k = 0; k < N_SLICES; k++) begin : g_slice
    ucs_ctl_slice #(.SLICE_IDX(k)) u_slice (
      .addr (table_addr),
      .data (ctl[k*SLICE_W +: SLICE_W])
    );
  end

  ucs_next_table u_next (
    .addr (table_addr),
    .nxt  (next_state)
  );

  ucs_state_reg u_state (
    .clk (clk),
    .rst (rst),
    .d   (next_state),
    .q   (cur_state)
  );

  assign state = cur_state;
endmodule

// File: rtl/ucs_sequencer_chk.sv
module ucs_sequencer_chk
  import ucs_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [OP_W-1:0]   opcode,
  input logic [FLAG_W-1:0] flags,
  input logic [CTL_W-1:0]  ctl,
  input logic [ST_W-1:0]   state,
  input logic [ST_W-1:0]   next_state
);
  AST_RESET_TO_FETCH: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> state == S_FETCH); // R1
  AST_STATE_FOLLOWS_TABLE: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> state == $past(next_state)); // R2
  AST_EMPTY_ENTRY_IDLE: assert property (@(posedge clk) disable iff (rst)
    ctl == '0 |-> next_state == S_FETCH); // R5
  AST_FETCH_TO_DECODE: assert property (@(posedge clk) disable iff (rst)
    (state == S_FETCH && ctl != '0) |-> next_state == S_ONE && ctl == C_FETCH); // R7
  AST_BRANCH_ON_Z: assert property (@(posedge clk) disable iff (rst)
    (opcode == OP_BEQ && state == S_ONE) |->
      next_state == (flags[FLG_Z] ? S_TWO : S_FETCH)); // R8
  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (opcode == OP_HALT && state == S_ONE) |-> next_state == S_ONE && ctl == C_STOPPED); // R10
endmodule

bind ucs_sequencer ucs_sequencer_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .opcode     (opcode),
  .flags      (flags),
  .ctl        (ctl),
  .state      (state),
  .next_state (next_state)
);

// File: tb/tb_ucs_sequencer.sv
module tb_ucs_sequencer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [9:0]  opcode = 10'h000;
  logic [3:0]  flags = 4'h0;
  logic [15:0] ctl;
  logic [4:0]  state;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  logic [4:0] model_st = 5'd0;

  always #10 clk = ~clk;

  ucs_sequencer dut (
    .clk(clk), .rst(rst), .opcode(opcode), .flags(flags),
    .ctl(ctl), .state(state)
  );

  // Reference: expected {ctl, next} restated from the requirements.
  function automatic logic [20:0] ref_entry(input logic [9:0] op,
      input logic [3:0] fl, input logic [4:0] st);
    logic known;
    known = (op == 10'h0A0) || (op == 10'h040) || (op == 10'h0C0) || (op == 10'h000);
    if (!known) return 21'h0;                                  // R5
    if (st == 5'd0) return {16'h000F, 5'd1};                   // R7
    if (op == 10'h0A0 && st == 5'd1) return {16'h0400, 5'd0};  // R11
    if (op == 10'h000 && st == 5'd1) return {16'h0080, 5'd1};  // R10
    if (op == 10'h040) begin                                   // R9
      if (st == 5'd1) return {16'h0103, 5'd2};
      if (st == 5'd2) return {16'h0220, 5'd3};
      if (st == 5'd3) return {16'h0830, 5'd0};
    end
    if (op == 10'h0C0) begin                                   // R8, R4: Z is bit 2
      if (st == 5'd1) return fl[2] ? {16'h0040, 5'd2} : {16'h0008, 5'd0};
      if (st == 5'd2) return {16'h1000, 5'd0};
    end
    return 21'h0;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [15:0] act,
                     input logic [15:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h (time %0t)", req, act, exp, $time);
    end
  endtask

  // Drive on the falling edge, check, then let the rising edge advance the model.
  task automatic step(input logic [9:0] op, input logic [3:0] fl, input logic r,
                      input string req);
    logic [20:0] e;
    @(negedge clk);
    opcode = op; flags = fl; rst = r;
    #1;
    e = ref_entry(op, fl, model_st);
    chk(state == model_st, {req, " R2 state"}, {11'h0, state}, {11'h0, model_st});
    chk(ctl == e[20:5], {req, " R6 ctl"}, ctl, e[20:5]);
    @(posedge clk);
    model_st = r ? 5'd0 : e[4:0];
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected<150000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin : stim
    logic [9:0] ops [5];
    ops[0] = 10'h0A0; ops[1] = 10'h040; ops[2] = 10'h0C0; ops[3] = 10'h000; ops[4] = 10'h3FF;
    void'($urandom(32'h5EED));

    // R1: reset holds state 0
    step(10'h040, 4'h0, 1'b1, "R1");
    step(10'h040, 4'h0, 1'b1, "R1");
    @(negedge clk); #1;
    chk(state == 5'd0, "R1 reset state", {11'h0, state}, 16'h0);

    // R11: NOP
    step(10'h0A0, 4'h0, 1'b0, "R11");
    step(10'h0A0, 4'h0, 1'b0, "R11");
    // R9: MOV through 4 states
    for (int i = 0; i < 4; i++) step(10'h040, 4'hF, 1'b0, "R9");
    // R8: BEQ taken (Z only) and not taken (all but Z) - R4 bit position
    for (int i = 0; i < 3; i++) step(10'h0C0, 4'b0100, 1'b0, "R8 taken");
    for (int i = 0; i < 2; i++) step(10'h0C0, 4'b1011, 1'b0, "R8 not taken");
    // R10: HALT stays in state 1
    for (int i = 0; i < 4; i++) step(10'h000, 4'h0, 1'b0, "R10");
    @(negedge clk); #1;
    chk(state == 5'd1, "R10 halt held", {11'h0, state}, 16'h1);
    step(10'h000, 4'h0, 1'b1, "R1 mid-halt");
    // R5: unlisted opcode gives zero and stays in state 0
    for (int i = 0; i < 3; i++) step(10'h3FF, 4'h5, 1'b0, "R5");
    @(negedge clk); #1;
    chk(ctl == 16'h0 && state == 5'd0, "R5 unlisted", ctl, 16'h0);

    // R3: in BEQ state 1, flipping Z mid-cycle changes ctl with no edge
    step(10'h0C0, 4'h0, 1'b0, "R3 setup");
    @(negedge clk);
    opcode = 10'h0C0; flags = 4'b0000; #1;
    chk(ctl == 16'h0008, "R3 Z low", ctl, 16'h0008);
    flags = 4'b0100; #1;
    chk(ctl == 16'h0040, "R3 Z high", ctl, 16'h0040);
    @(posedge clk);
    model_st = 5'd2;
    step(10'h0C0, 4'h0, 1'b0, "R8 tail");

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      logic [9:0] op;
      logic [3:0] fl;
      logic r;
      op = ops[$urandom_range(0, 4)];
      fl = 4'($urandom());
      r = ($urandom_range(0, 63) == 0);
      step(op, fl, r, "R2 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule